// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block produces periodic interrupt requests from a reference clock. A 15-bit up-counter runs while the module is enabled. Software chooses one of eight fixed division ratios, from 8 up to 32768, and the block raises an interrupt flag each time the counter's low bits at the chosen width all reach one. A level interrupt request goes out while the flag is set and interrupts are enabled.

Software reaches the block through one 8-bit control/status register at address 0x1C, using a plain bus with an address, a write strobe, a read strobe, write data and combinational read data. The flag is cleared by writing 1 to a write-only acknowledge bit. The rate select should only be changed while the module is disabled. If it is changed while running, the next period is undefined, but the counter keeps running and flags keep appearing.

Top module: `period_irq_unit`

## Requirements
- R1: After reset every register bit is 0, so a read of address 0x1C returns 0x00 and `irq` is low.
- R2: Read data at address 0x1C is laid out as follows: bit 7 is the flag, bits 6..4 are the rate select (bit 6 most significant), bit 3 reads 0, bit 2 is the interrupt enable, bit 1 is the module enable and bit 0 reads 0. `bus_rdata` is 0x00 whenever `bus_rd` is low or the address is not 0x1C.
- R3: Rate select codes map to dividers as follows: 000=32768, 001=8192, 010=2048, 011=128, 100=64, 101=32, 110=16, 111=8.
- R4: A write that sets the module enable is captured at clock edge E. The flag then sets at edge E+D, where D is the selected divider, and again every D cycles after that.
- R5: A write to 0x1C with bit 3 = 1 clears the flag at that edge. A write with bit 3 = 0 leaves the flag unchanged.
- R6: If a counter rollover and an acknowledge write fall on the same edge, the flag is set after that edge.
- R7: `irq` is high exactly when the flag is set and the interrupt enable (bit 2) is 1. The flag still sets while the interrupt enable is 0.
- R8: While the module enable is 0, the counter is held at zero and no new flag is set. A flag that is already set stays set until it is acknowledged.
- R9: Writes to any address other than 0x1C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe, enables read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A counter that is off by one, or a wrong tap mask, moves the first rise of `irq` away from exactly D cycles after the enabling write. This shows on the first period at every rate, so the bench measures both the first and the second period at all eight codes. A flag priority that is wrong, or one that is lost while disabled, shows up one cycle after the acknowledge or disable write, as a mismatch between `irq` and bit 7 of the readback. A counter that is not cleared while idle shows up as an early first flag after re-enabling.

// File: rtl/period_irq_pkg.sv
package period_irq_pkg;

  localparam int CNT_W   = 15;
  localparam int RSEL_W  = 3;
  localparam int REG_W   = 8;

  localparam int FLAG_BIT = 7;
  localparam int RSEL_HI  = 6;
  localparam int RSEL_LO  = 4;
  localparam int ACK_BIT  = 3;
  localparam int IE_BIT   = 2;
  localparam int EN_BIT   = 1;

  typedef struct packed {
    logic [RSEL_W-1:0] rsel;
    logic              ie;
    logic              en;
  } cfg_t;

  // Number of low counter bits that form one period for a rate code.
  function automatic int tap_bits(input logic [RSEL_W-1:0] sel);
    case (sel)
      3'd0:    return 15;
      3'd1:    return 13;
      3'd2:    return 11;
      3'd3:    return 7;
      3'd4:    return 6;
      3'd5:    return 5;
      3'd6:    return 4;
      default: return 3;
    endcase
  endfunction

  // Mask of the counter bits that must all be one at a rollover.
  function automatic logic [CNT_W-1:0] tap_mask(input logic [RSEL_W-1:0] sel);
    logic [CNT_W-1:0] m;
    int nb;
    nb = tap_bits(sel);
    for (int i = 0; i < CNT_W; i++) m[i] = (i < nb);
    return m;
  endfunction

endpackage

// File: rtl/period_irq_counter.sv
module period_irq_counter
  import period_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] mask,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  // A period ends when every bit under the tap mask is one.
  assign wrap = run && ((count & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + 1'b1;
    else          count <= '0;
  end

endmodule

// File: rtl/period_irq_regs.sv
module period_irq_regs
  import period_irq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              wrap,
  output cfg_t              cfg,
  output logic              flag,
  output logic              ack_evt,
  output logic [REG_W-1:0]  bus_rdata
);

  logic hit;
  logic wr_hit;

  assign hit     = (bus_addr == REG_ADDR);
  assign wr_hit  = bus_wr && hit;
  assign ack_evt = wr_hit && bus_wdata[ACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_hit) begin
      cfg.rsel <= bus_wdata[RSEL_HI:RSEL_LO];
      cfg.ie   <= bus_wdata[IE_BIT];
      cfg.en   <= bus_wdata[EN_BIT];
    end
  end

  // Rollover has priority over acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (wrap)    flag <= 1'b1;
    else if (ack_evt) flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) begin
      bus_rdata[FLAG_BIT]        = flag;
      bus_rdata[RSEL_HI:RSEL_LO] = cfg.rsel;
      bus_rdata[IE_BIT]          = cfg.ie;
      bus_rdata[EN_BIT]          = cfg.en;
    end
  end

endmodule

// File: rtl/period_irq_unit.sv
module period_irq_unit
  import period_irq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);

  cfg_t             cfg;
  logic             flag;
  logic             ack_evt;
  logic             wrap;
  logic             mod_en;
  logic             int_en;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] mask;

  assign mod_en = cfg.en;
  assign int_en = cfg.ie;
  assign mask   = tap_mask(cfg.rsel);

  period_irq_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .wrap      (wrap),
    .cfg       (cfg),
    .flag      (flag),
    .ack_evt   (ack_evt),
    .bus_rdata (bus_rdata)
  );

  period_irq_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mod_en),
    .mask  (mask),
    .count (count),
    .wrap  (wrap)
  );

  assign irq = flag && int_en;

endmodule

// File: rtl/period_irq_chk.sv
module period_irq_chk
  import period_irq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              irq,
  input logic              flag,
  input logic              wrap,
  input logic              ack_evt,
  input logic              mod_en,
  input logic [CNT_W-1:0]  count
);

  // R6: a rollover always leaves the flag set, acknowledge or not
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  // R4: the flag only rises after a rollover
  assert_flag_from_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap));

  // R5: an acknowledge without a rollover clears the flag
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !wrap) |=> !flag);

  // R8: an idle module leaves the counter at zero
  assert_idle_count_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (count == '0));

  // R8: a flag cannot rise while the module is off
  assert_no_flag_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !flag) |=> !flag);

  // R7: a request never stands without the flag
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  // R2: unselected reads return zero
  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (bus_addr == REG_ADDR)) |-> (bus_rdata == '0));

endmodule

bind period_irq_unit period_irq_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .flag      (flag),
  .wrap      (wrap),
  .ack_evt   (ack_evt),
  .mod_en    (mod_en),
  .count     (count)
);

// File: tb/tb_period_irq_unit.sv
`timescale 1ns/1ps
module tb_period_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] RA = 8'h1C;
  localparam int DIVS [8] = '{32768, 8192, 2048, 128, 64, 32, 16, 8};

  always #5 clk = ~clk;

  period_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] cfgw(input int sel, input bit ack, input bit ie, input bit en);
    return 8'((sel % 8) * 16 + (ack ? 8 : 0) + (ie ? 4 : 0) + (en ? 2 : 0));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // Counts edges from the current negedge until irq is seen high.
  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (!irq && n < limit) begin
      step();
      n++;
    end
  endtask

  // First and second period at a rate, acknowledging after the first.
  task automatic measure(input int sel, output int first, output int second);
    int n;
    bit prev;
    wr_at(RA, 8'h08);
    wr_at(RA, cfgw(sel, 0, 1, 1));
    n = 0; first = -1; second = -1; prev = 1'b0;
    while (second < 0 && n < 70000) begin
      step();
      n++;
      bus_wr = 1'b0;
      if (irq && !prev) begin
        if (first < 0) begin
          first = n;
          bus_addr = RA; bus_wdata = cfgw(sel, 1, 1, 1); bus_wr = 1'b1;
        end else begin
          second = n - first;
        end
      end
      prev = irq;
    end
    bus_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int f, s, n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_at(RA, rd);
    check(rd == 8'h00, "R1 reset readback", rd, 0);
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2: layout, write-only and reserved bits read 0
    wr_at(RA, 8'hFF);
    rd_at(RA, rd);
    check(rd == 8'h76, "R2 readback layout", rd, 8'h76);
    bus_addr = RA; bus_rd = 1'b0; #1;
    check(bus_rdata == 8'h00, "R2 no read strobe", bus_rdata, 0);
    rd_at(8'h1D, rd);
    check(rd == 8'h00, "R2 other address read", rd, 0);

    // R9: foreign address writes are ignored
    wr_at(8'h1D, 8'h00);
    wr_at(8'h00, 8'h08);
    rd_at(RA, rd);
    check((rd & 8'h7F) == 8'h76, "R9 foreign write ignored", rd & 8'h7F, 8'h76);

    // R3 R4: every rate, first and second period
    for (int sel = 0; sel < 8; sel++) begin
      measure(sel, f, s);
      check(f == DIVS[sel], $sformatf("R3 R4 first period code %0d", sel), f, DIVS[sel]);
      check(s == DIVS[sel], $sformatf("R3 R4 second period code %0d", sel), s, DIVS[sel]);
    end

    // R5 R6: acknowledge and collision with rollover (divider 8)
    wr_at(RA, 8'h08);
    wr_at(RA, cfgw(7, 0, 1, 1));
    repeat (8) step();
    check(irq == 1'b1, "R4 flag at 8", irq, 1);
    wr_at(RA, cfgw(7, 1, 1, 1));
    check(irq == 1'b0, "R5 ack clears", irq, 0);
    repeat (6) step();
    check(irq == 1'b0, "R5 still clear before rollover", irq, 0);
    wr_at(RA, cfgw(7, 1, 1, 1));
    check(irq == 1'b1, "R6 rollover beats ack", irq, 1);
    wr_at(RA, cfgw(7, 1, 1, 1));
    check(irq == 1'b0, "R5 later ack clears", irq, 0);
    repeat (7) step();
    check(irq == 1'b1, "R4 flag at 24", irq, 1);
    wr_at(RA, cfgw(7, 0, 1, 1));
    check(irq == 1'b1, "R5 zero ack keeps flag", irq, 1);

    // R8: disable keeps the flag, no new flag, counter held at zero
    wr_at(RA, cfgw(7, 0, 1, 0));
    repeat (40) step();
    check(irq == 1'b1, "R8 flag kept while off", irq, 1);
    wr_at(RA, cfgw(7, 1, 1, 0));
    repeat (40) step();
    check(irq == 1'b0, "R8 no flag while off", irq, 0);
    rd_at(RA, rd);
    check(rd == 8'h74, "R8 readback while off", rd, 8'h74);
    wr_at(RA, cfgw(7, 0, 1, 1));
    repeat (5) step();
    wr_at(RA, cfgw(7, 0, 1, 0));
    repeat (3) step();
    wr_at(RA, cfgw(7, 0, 1, 1));
    wait_irq(100, n);
    check(n == 8, "R8 counter restarts from zero", n, 8);

    // R7: flag sets with interrupts masked, request follows the enable
    wr_at(RA, 8'h08);
    wr_at(RA, cfgw(7, 0, 0, 1));
    repeat (10) step();
    rd_at(RA, rd);
    check(rd[7] == 1'b1, "R7 flag sets while masked", rd[7], 1);
    check(irq == 1'b0, "R7 masked irq low", irq, 0);
    wr_at(RA, cfgw(7, 0, 1, 1));
    check(irq == 1'b1, "R7 unmask raises irq", irq, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule